// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block watches one digital input and tags every change of its level with the shared, synchronized time value of the system. The input passes through a short flop synchronizer. The delay that this synchronizer adds is known, so it is subtracted from every tag. Each stored time therefore names the clock cycle in which the new level was first sampled. A software or hardware consumer can later match those times against samples taken elsewhere on the same time base. The control cycle can be as long as it likes, because the precision of a tag does not depend on how often it is read out.

Edges are gathered per control window. Within a window the unit counts rising and falling edges and keeps the time of the latest edge of each kind. It queues the times of the first rising edges, up to a fixed depth (ten by default), so that pulse counts and frequencies can be derived. A one-cycle window strobe freezes all of this into a snapshot register set in one step and starts a fresh window. The snapshot stays put until the next strobe. The queued times are read through an index input.

Top module: `edge_stamp_unit`

## Requirements
- R1: While and after reset, until the first window strobe, every snapshot output reads zero: level, both valid flags, both times, both counts, the overflow flag and every queue entry.
- R2: A rising edge gets a timestamp equal to the value of `time_now` at the clock edge where the input was first sampled high. `snap_rise_time` holds the latest rising timestamp seen, and it keeps its value through windows that have no rising edge. `snap_rise_valid` is 1 exactly when the closed window held at least one rising edge.
- R3: Falling edges follow the same rules as R2, using `snap_fall_time` and `snap_fall_valid`.
- R4: `snap_level` equals the synchronized input level after the last edge that was credited to the closed window.
- R5: `snap_rise_cnt` and `snap_fall_cnt` count the edges of each kind in the closed window. They saturate at 2^CNT_W-1 (255 by default) and do not wrap.
- R6: The queue keeps the timestamps of the first DEPTH (10) rising edges of a window in order of arrival. `rd_idx` = 0 selects the oldest entry. An index with no stored edge, including any index of DEPTH or above, reads zero.
- R7: `snap_overflow` is 1 when a window held more than DEPTH rising edges. The extra edges are still counted, but they are not queued.
- R8: The snapshot changes only on the clock edge that samples `cycle_strobe` high. A level change sampled at clock edge E is credited to the window closed by the first strobe sampled at edge E+3 or later. A strobe sampled at E+2 or earlier leaves that change to the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_in | input | 1 | Monitored digital input (asynchronous) |
| time_now | input | TIME_W | Shared synchronized time value |
| cycle_strobe | input | 1 | One-cycle pulse that closes the window |
| rd_idx | input | IDX_W | Queue entry select for readout |
| snap_level | output | 1 | Frozen input level |
| snap_rise_valid | output | 1 | A rising edge occurred in the closed window |
| snap_fall_valid | output | 1 | A falling edge occurred in the closed window |
| snap_rise_time | output | TIME_W | Latest rising-edge timestamp |
| snap_fall_time | output | TIME_W | Latest falling-edge timestamp |
| snap_rise_cnt | output | CNT_W | Rising edges in the closed window |
| snap_fall_cnt | output | CNT_W | Falling edges in the closed window |
| snap_overflow | output | 1 | More rising edges than queue entries |
| snap_rd_time | output | TIME_W | Queue entry selected by `rd_idx` |

## Verification
The hardest case to reach is an edge that lands right on a window boundary, in the clock where the strobe closes the window. At that point only the synchronizer latency decides which window receives the edge. The stimulus changes the input and then places the strobe exactly two cycles later, which must exclude the change, and on the next try three cycles later, which must include it. A second hard case is the overflow of the queue together with counter saturation. To get there, single-cycle pulses are driven back to back: thirteen pulses in one window, then several hundred in another.

// File: rtl/ets_pkg.sv
package ets_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/ets_sync.sv
module ets_sync
  import ets_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_in,
  output logic       level_o,
  output edge_kind_e kind_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              level_q;
  logic              level_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = sig_in;
      end else begin : g_rest
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  assign level_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      level_q <= 1'b0;
    end else begin
      chain_q <= chain_d;
      level_q <= level_d;
    end
  end

  always_comb begin
    case ({chain_q[STAGES-1], level_q})
      2'b10:   kind_o = EV_RISE;
      2'b01:   kind_o = EV_FALL;
      default: kind_o = EV_NONE;
    endcase
  end

  assign level_o = level_q;

  AST_RISE_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == EV_RISE) |=> level_o); // R4
  AST_FALL_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == EV_FALL) |=> !level_o); // R4
endmodule

// File: rtl/ets_stamp.sv
module ets_stamp #(
  parameter int TIME_W = 64,
  parameter int LAT    = 2
) (
  input  logic [TIME_W-1:0] time_now,
  output logic [TIME_W-1:0] stamp_o
);
  localparam logic [TIME_W-1:0] COMP = TIME_W'(LAT);

  assign stamp_o = time_now - COMP;
endmodule

// File: rtl/ets_work.sv
module ets_work
  import ets_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe,
  input  edge_kind_e                   kind,
  input  logic [TIME_W-1:0]            stamp,
  output logic [CNT_W-1:0]             rise_cnt,
  output logic [CNT_W-1:0]             fall_cnt,
  output logic [TIME_W-1:0]            last_rise,
  output logic [TIME_W-1:0]            last_fall,
  output logic                         rise_vld,
  output logic                         fall_vld,
  output logic                         ovf,
  output logic [DEPTH-1:0][TIME_W-1:0] fifo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic              is_rise, is_fall;
  logic [CNT_W-1:0]  rc_q, fc_q, base_rc, base_fc, rc_d, fc_d;
  logic              rv_q, fv_q, ov_q, rv_d, fv_d, ov_d;
  logic [TIME_W-1:0] lr_q, lf_q;
  logic              cnt_en;

  assign is_rise = (kind == EV_RISE);
  assign is_fall = (kind == EV_FALL);
  assign cnt_en  = strobe | is_rise | is_fall;

  always_comb begin
    base_rc = strobe ? '0 : rc_q;
    base_fc = strobe ? '0 : fc_q;
    rc_d    = base_rc;
    fc_d    = base_fc;
    rv_d    = strobe ? 1'b0 : rv_q;
    fv_d    = strobe ? 1'b0 : fv_q;
    ov_d    = strobe ? 1'b0 : ov_q;
    if (is_rise) begin
      rc_d = (base_rc == CNT_MAX) ? CNT_MAX : base_rc + 1'b1;
      rv_d = 1'b1;
      if (base_rc >= DEPTH_C) ov_d = 1'b1;
    end
    if (is_fall) begin
      fc_d = (base_fc == CNT_MAX) ? CNT_MAX : base_fc + 1'b1;
      fv_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
      fc_q <= '0;
      rv_q <= 1'b0;
      fv_q <= 1'b0;
      ov_q <= 1'b0;
    end else if (cnt_en) begin
      rc_q <= rc_d;
      fc_q <= fc_d;
      rv_q <= rv_d;
      fv_q <= fv_d;
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= '0;
    end else if (is_rise) begin
      lr_q <= stamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q <= '0;
    end else if (is_fall) begin
      lf_q <= stamp;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              hit;
      logic              en;
      logic [TIME_W-1:0] d;
      logic [TIME_W-1:0] q;
      assign hit = is_rise && (base_rc == CNT_W'(g));
      assign en  = strobe | hit;
      assign d   = hit ? stamp : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (en) begin
          q <= d;
        end
      end
      assign fifo[g] = q;
    end
  endgenerate

  assign rise_cnt  = rc_q;
  assign fall_cnt  = fc_q;
  assign last_rise = lr_q;
  assign last_fall = lf_q;
  assign rise_vld  = rv_q;
  assign fall_vld  = fv_q;
  assign ovf       = ov_q;

  AST_OVF_NEEDS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (rc_q > DEPTH_C)); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (rc_q >= $past(rc_q)) && (fc_q >= $past(fc_q))); // R5
  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (rc_q <= 1) && (fc_q <= 1)); // R8
  AST_VALID_MATCHES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q == (rc_q != '0)); // R2
endmodule

// File: rtl/ets_snap.sv
module ets_snap #(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe,
  input  logic                         level,
  input  logic [CNT_W-1:0]             rise_cnt,
  input  logic [CNT_W-1:0]             fall_cnt,
  input  logic [TIME_W-1:0]            last_rise,
  input  logic [TIME_W-1:0]            last_fall,
  input  logic                         rise_vld,
  input  logic                         fall_vld,
  input  logic                         ovf,
  input  logic [DEPTH-1:0][TIME_W-1:0] fifo,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic                         s_level,
  output logic                         s_rise_vld,
  output logic                         s_fall_vld,
  output logic [TIME_W-1:0]            s_rise_time,
  output logic [TIME_W-1:0]            s_fall_time,
  output logic [CNT_W-1:0]             s_rise_cnt,
  output logic [CNT_W-1:0]             s_fall_cnt,
  output logic                         s_ovf,
  output logic [TIME_W-1:0]            s_rd_time
);
  logic [DEPTH-1:0][TIME_W-1:0] sfifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_level     <= 1'b0;
      s_rise_vld  <= 1'b0;
      s_fall_vld  <= 1'b0;
      s_rise_time <= '0;
      s_fall_time <= '0;
      s_rise_cnt  <= '0;
      s_fall_cnt  <= '0;
      s_ovf       <= 1'b0;
      sfifo_q     <= '0;
    end else if (strobe) begin
      s_level     <= level;
      s_rise_vld  <= rise_vld;
      s_fall_vld  <= fall_vld;
      s_rise_time <= last_rise;
      s_fall_time <= last_fall;
      s_rise_cnt  <= rise_cnt;
      s_fall_cnt  <= fall_cnt;
      s_ovf       <= ovf;
      sfifo_q     <= fifo;
    end
  end

  always_comb begin
    s_rd_time = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) s_rd_time = sfifo_q[i];
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(s_rise_cnt) && $stable(s_fall_cnt) && $stable(s_rise_time)
                && $stable(s_fall_time) && $stable(s_level) && $stable(s_ovf)); // R8
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import ets_pkg::*;
#(
  parameter int TIME_W      = 64,
  parameter int DEPTH       = 10,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic [TIME_W-1:0] time_now,
  input  logic              cycle_strobe,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              snap_level,
  output logic              snap_rise_valid,
  output logic              snap_fall_valid,
  output logic [TIME_W-1:0] snap_rise_time,
  output logic [TIME_W-1:0] snap_fall_time,
  output logic [CNT_W-1:0]  snap_rise_cnt,
  output logic [CNT_W-1:0]  snap_fall_cnt,
  output logic              snap_overflow,
  output logic [TIME_W-1:0] snap_rd_time
);
  logic rst_meta_q, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  logic                         level;
  edge_kind_e                   kind;
  logic [TIME_W-1:0]            stamp;
  logic [CNT_W-1:0]             w_rc, w_fc;
  logic [TIME_W-1:0]            w_lr, w_lf;
  logic                         w_rv, w_fv, w_ov;
  logic [DEPTH-1:0][TIME_W-1:0] w_fifo;

  ets_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .sig_in(sig_in), .level_o(level), .kind_o(kind)
  );

  ets_stamp #(.TIME_W(TIME_W), .LAT(SYNC_STAGES)) u_stamp (
    .time_now(time_now), .stamp_o(stamp)
  );

  ets_work #(.TIME_W(TIME_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_work (
    .clk(clk), .rst_n(rst_sn), .strobe(cycle_strobe), .kind(kind), .stamp(stamp),
    .rise_cnt(w_rc), .fall_cnt(w_fc), .last_rise(w_lr), .last_fall(w_lf),
    .rise_vld(w_rv), .fall_vld(w_fv), .ovf(w_ov), .fifo(w_fifo)
  );

  ets_snap #(.TIME_W(TIME_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_snap (
    .clk(clk), .rst_n(rst_sn), .strobe(cycle_strobe), .level(level),
    .rise_cnt(w_rc), .fall_cnt(w_fc), .last_rise(w_lr), .last_fall(w_lf),
    .rise_vld(w_rv), .fall_vld(w_fv), .ovf(w_ov), .fifo(w_fifo), .rd_idx(rd_idx),
    .s_level(snap_level), .s_rise_vld(snap_rise_valid), .s_fall_vld(snap_fall_valid),
    .s_rise_time(snap_rise_time), .s_fall_time(snap_fall_time),
    .s_rise_cnt(snap_rise_cnt), .s_fall_cnt(snap_fall_cnt), .s_ovf(snap_overflow),
    .s_rd_time(snap_rd_time)
  );
endmodule

// File: tb/edge_stamp_unit_tb.sv
module edge_stamp_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TIME_W = 64;
  localparam int DEPTH  = 10;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = $clog2(DEPTH + 1);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n, sig, stb;
  logic [IDX_W-1:0]  rd_idx;
  logic [63:0]       tnow = 64'h0000_0001_FFFF_FFF0;
  logic              s_lvl, s_rv, s_fv, s_ov;
  logic [63:0]       s_rt, s_ft, s_rd;
  logic [CNT_W-1:0]  s_rc, s_fc;

  always @(negedge clk) tnow <= tnow + 64'd1;

  edge_stamp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .time_now(tnow), .cycle_strobe(stb),
    .rd_idx(rd_idx), .snap_level(s_lvl), .snap_rise_valid(s_rv), .snap_fall_valid(s_fv),
    .snap_rise_time(s_rt), .snap_fall_time(s_ft), .snap_rise_cnt(s_rc),
    .snap_fall_cnt(s_fc), .snap_overflow(s_ov), .snap_rd_time(s_rd)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // model: pending edges {rise, time}, open window, expected snapshot
  logic [64:0] pend[$];
  int          m_rc = 0, m_fc = 0;
  logic        m_rv = 0, m_fv = 0, m_ov = 0, m_lvl = 0;
  logic [63:0] m_lr = 0, m_lf = 0;
  logic [63:0] m_fifo[$];
  int          e_rc = 0, e_fc = 0;
  logic        e_rv = 0, e_fv = 0, e_ov = 0, e_lvl = 0;
  logic [63:0] e_lr = 0, e_lf = 0;
  logic [63:0] e_fifo[$];

  task automatic chk(input string rq, input string ctx, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", rq, ctx, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: change input, push expected edge into the scoreboard queue
  task automatic chg(input logic v);
    @(negedge clk); #1;
    if (v !== sig) pend.push_back({v, tnow});
    sig = v;
  endtask

  task automatic apply_edge(input logic [64:0] ev);
    if (ev[64]) begin
      m_rc = (m_rc == CMAX) ? CMAX : m_rc + 1;
      m_rv = 1; m_lr = ev[63:0]; m_lvl = 1;
      if (m_fifo.size() < DEPTH) m_fifo.push_back(ev[63:0]); else m_ov = 1;
    end else begin
      m_fc = (m_fc == CMAX) ? CMAX : m_fc + 1;
      m_fv = 1; m_lf = ev[63:0]; m_lvl = 0;
    end
  endtask

  task automatic strobe();
    logic [63:0] ts;
    @(negedge clk); #1;
    ts = tnow;
    stb = 1;
    // R8: change sampled at E is credited if the strobe is sampled at E+3 or later
    while (pend.size() > 0 && (pend[0][63:0] + 64'd3 <= ts)) apply_edge(pend.pop_front());
    e_rc = m_rc; e_fc = m_fc; e_rv = m_rv; e_fv = m_fv; e_ov = m_ov; e_lvl = m_lvl;
    e_lr = m_lr; e_lf = m_lf; e_fifo = m_fifo;
    m_rc = 0; m_fc = 0; m_rv = 0; m_fv = 0; m_ov = 0; m_fifo.delete();
    @(negedge clk); #1;
    stb = 0;
  endtask

  // monitor: compares snapshot, popping queue entries in order
  task automatic verify(input string ctx);
    logic [63:0] q[$];
    logic [63:0] exp;
    q = e_fifo;
    @(negedge clk); #1;
    chk("R4", ctx, {63'd0, s_lvl}, {63'd0, e_lvl});
    chk("R2", ctx, {63'd0, s_rv}, {63'd0, e_rv});
    chk("R3", ctx, {63'd0, s_fv}, {63'd0, e_fv});
    chk("R2", ctx, s_rt, e_lr);
    chk("R3", ctx, s_ft, e_lf);
    chk("R5", ctx, 64'(s_rc), 64'(e_rc));
    chk("R5", ctx, 64'(s_fc), 64'(e_fc));
    chk("R7", ctx, {63'd0, s_ov}, {63'd0, e_ov});
    for (int i = 0; i <= DEPTH; i++) begin
      rd_idx = IDX_W'(i);
      #1;
      exp = (q.size() > 0) ? q.pop_front() : 64'd0;
      chk("R6", ctx, s_rd, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sig = 0; stb = 0; rd_idx = '0;
    idle(3);
    #1 rst_n = 1;
    idle(4);
    // R1: reset state
    #1;
    chk("R1", "reset", {63'd0, s_lvl}, 64'd0);
    chk("R1", "reset", {63'd0, s_rv | s_fv | s_ov}, 64'd0);
    chk("R1", "reset", s_rt | s_ft, 64'd0);
    chk("R1", "reset", 64'(s_rc) | 64'(s_fc), 64'd0);
    for (int i = 0; i <= DEPTH; i++) begin
      rd_idx = IDX_W'(i); #1;
      chk("R1", "reset queue", s_rd, 64'd0);
    end

    // window A: three rises, two falls, ends high
    chg(1); idle(4); chg(0); idle(3); chg(1); idle(2); chg(0); idle(2); chg(1); idle(5);
    strobe(); verify("A mixed edges");
    // window B: no edges, times persist, valids clear
    idle(5); strobe(); verify("B quiet R2");
    // window C: 13 single-cycle pulses -> overflow
    for (int k = 0; k < 13; k++) begin chg(0); chg(1); end
    idle(4); strobe(); verify("C overflow R7");
    // hold: edges without strobe leave snapshot unchanged
    chg(0); idle(4); verify("hold R8");
    // boundary: strobe sampled two edges after the change excludes it
    chg(1); idle(1); strobe(); verify("boundary excluded R8");
    // three edges after: included
    chg(0); idle(2); strobe(); verify("boundary included R8");
    // saturation of counters
    for (int k = 0; k < 300; k++) begin chg(1); chg(0); end
    idle(4); strobe(); verify("saturate R5");
    idle(4); strobe(); verify("after saturate");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule